// File: doc/BRIEF.md
# Wide ROM Read Buffer Bridge

This block joins a 64-bit-wide read-only array to a 32-bit internal read bus that a CPU and a DMA master share. A claimed read whose 64-bit row is not already held starts a two-cycle array fetch. The fetched row is kept in a one-row buffer with a tag. A later read of either 32-bit half of that row is then served in a single cycle without touching the array again. Byte, halfword and word reads are placed on big-endian lanes, and the unused lanes read as zero.

A three-bit mode input gates the address decode. Writes, misaligned requests and the reserved size code complete at once with an error flag, and they leave the buffer untouched. The control is a three-state machine. In `ST_IDLE` the block decodes the request and answers hits and errors. On a miss it moves from `ST_IDLE` to `ST_FETCH`. `ST_FETCH` always moves to `ST_LOAD`, which is the cycle in which array data is valid. `ST_LOAD` always returns to `ST_IDLE` and writes the buffer on the way. The request is then answered as a hit.

The master holds its request (valid, address, size, write) stable until it sees ready, and it drops or changes the request in the next cycle. The array contents are computed: row r holds upper word `(r*0x01000193) ^ 0xC3A50F1E` and lower word `(r*0x9E3779B9) + 0x5A5A`, both wrapping at 32 bits.

Top module: `rom_bridge`

## Requirements
- R1: After reset, ready and error are low, and the buffer is invalid, so the first claimed read is a miss.
- R2: A request is claimed only when address bits 31:18 are all zero (byte window 0x00000000 to 0x0003FFFF). Outside the window, ready and error stay low.
- R3: Mode values 0 and 1 enable the window. Values 2 to 7 disable it, and requests are then not claimed: ready and error stay low.
- R4: A claimed, aligned read that misses holds ready low for three cycles. Ready rises in the fourth cycle of the request, with the data.
- R5: A claimed, aligned read whose row index (address bits 17:3) matches the valid buffer tag gets ready in its first cycle.
- R6: A word read (size code 2) returns array row[63:32] when address bit 2 is 0, and row[31:0] when it is 1.
- R7: A halfword read (size code 1) puts the halfword at offset 0 on bits 31:16 and the halfword at offset 2 on bits 15:0. The other bits are zero.
- R8: A byte read (size code 0) at offset k within its word puts the byte on bits 31-8k down to 24-8k. The other bits are zero.
- R9: A halfword at an odd address, a word whose address bits 1:0 are not zero, or size code 3 completes in one cycle with ready and error high and data zero. It does not change the buffer.
- R10: A claimed write completes in one cycle with ready and error high. It reads nothing and does not change the buffer.
- R11: Any change of the mode input invalidates the buffer, so the next read of the previously buffered row is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 3 | Operating mode; 0 or 1 enables the window |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| rsp_ready | output | 1 | Request completes this cycle |
| rsp_data | output | 32 | Read data, lane-steered |
| rsp_err | output | 1 | Error completion (write, misaligned, reserved size) |

## Verification
The assertions assume that a master keeps its request stable while ready is low. They also assume that the mode input does not change while a miss is in flight, because a change during `ST_FETCH` or `ST_LOAD` would only cause a second miss. The stimulus drives each request at the falling edge and holds it until ready, or for six cycles when no answer is expected. Mode changes happen only between requests. Random row indices are drawn mostly from a small set, so that hits, misses and buffer replacement all occur often.

// File: rtl/rom_bridge_pkg.sv
`timescale 1ns/1ps
package rom_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2
    } brg_state_e;

    // Computed array contents; row index widened to 32 bits
    function automatic logic [63:0] rom_row_value(input logic [31:0] idx);
        logic [31:0] hi_w;
        logic [31:0] lo_w;
        hi_w = (idx * 32'h0100_0193) ^ 32'hC3A5_0F1E;
        lo_w = (idx * 32'h9E37_79B9) + 32'h0000_5A5A;
        return {hi_w, lo_w};
    endfunction

endpackage

// File: rtl/rom_array.sv
`timescale 1ns/1ps
module rom_array #(
    parameter int ROW_W  = 15,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data
);
    import rom_bridge_pkg::*;

    logic [ROW_W-1:0]  row_q;
    logic [DATA_W-1:0] data_q;

    // Stage one: capture row index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (rd_start) begin
            row_q <= rd_row;
        end
    end

    // Stage two: registered array output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= DATA_W'(rom_row_value(32'(row_q)));
        end
    end

    assign rd_data = data_q;

endmodule

// File: rtl/rom_lane_steer.sv
`timescale 1ns/1ps
module rom_lane_steer #(
    parameter int ROW_DW = 64,
    parameter int BUS_DW = 32
) (
    input  logic [ROW_DW-1:0] row,
    input  logic [2:0]        offs,
    input  logic [1:0]        size,
    output logic [BUS_DW-1:0] data
);
    import rom_bridge_pkg::*;

    logic [BUS_DW-1:0] word_sel;
    logic [BUS_DW-1:0] lane_mask;

    // Lower address lives in the upper half (big-endian)
    assign word_sel = offs[2] ? row[BUS_DW-1:0] : row[ROW_DW-1:BUS_DW];

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: lane_mask = 32'hFF00_0000 >> (5'(offs[1:0]) << 3);
            SZ_HALF: lane_mask = offs[1] ? 32'h0000_FFFF : 32'hFFFF_0000;
            SZ_WORD: lane_mask = 32'hFFFF_FFFF;
            SZ_RSVD: lane_mask = 32'h0000_0000;
        endcase
    end

    assign data = word_sel & lane_mask;

endmodule

// File: rtl/rom_bridge.sv
`timescale 1ns/1ps
module rom_bridge #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 18,
    parameter int BUS_DW   = 32,
    parameter int ROW_DW   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_size,
    output logic              rsp_ready,
    output logic [31:0]       rsp_data,
    output logic              rsp_err
);
    import rom_bridge_pkg::*;

    localparam int OFS_W = $clog2(ROW_DW / 8);
    localparam int ROW_W = WIN_BITS - OFS_W;

    brg_state_e        state_q, state_d;
    logic [2:0]        mode_q;
    logic              buf_valid;
    logic [ROW_W-1:0]  buf_tag;
    logic [ROW_DW-1:0] buf_row;
    logic [ROW_W-1:0]  pend_tag;
    logic [ROW_DW-1:0] arr_data;
    logic [BUS_DW-1:0] steer_data;

    logic in_window, mode_en, claim, misaligned, bad_req, hit;
    logic arr_start, buf_load;
    logic [ROW_W-1:0] req_row;

    assign req_row    = req_addr[WIN_BITS-1:OFS_W];
    assign in_window  = (req_addr[ADDR_W-1:WIN_BITS] == '0);
    assign mode_en    = (mode == 3'd0) || (mode == 3'd1);
    assign claim      = req_valid && mode_en && in_window;
    assign misaligned = ((acc_size_e'(req_size) == SZ_HALF) && req_addr[0])
                     || ((acc_size_e'(req_size) == SZ_WORD) && (req_addr[1:0] != 2'b00))
                     ||  (acc_size_e'(req_size) == SZ_RSVD);
    assign bad_req    = req_write || misaligned;
    assign hit        = buf_valid && (buf_tag == req_row);

    rom_array #(.ROW_W(ROW_W), .DATA_W(ROW_DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_start(arr_start),
        .rd_row  (req_row),
        .rd_data (arr_data)
    );

    rom_lane_steer #(.ROW_DW(ROW_DW), .BUS_DW(BUS_DW)) u_steer (
        .row (buf_row),
        .offs(req_addr[OFS_W-1:0]),
        .size(req_size),
        .data(steer_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        rsp_ready = 1'b0;
        rsp_err   = 1'b0;
        rsp_data  = '0;
        arr_start = 1'b0;
        buf_load  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (claim) begin
                    if (bad_req) begin
                        rsp_ready = 1'b1;
                        rsp_err   = 1'b1;
                    end else if (hit) begin
                        rsp_ready = 1'b1;
                        rsp_data  = steer_data;
                    end else begin
                        arr_start = 1'b1;
                        state_d   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD: begin
                buf_load = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Row buffer, tag and mode tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 3'd0;
            buf_valid <= 1'b0;
            buf_tag   <= '0;
            buf_row   <= '0;
            pend_tag  <= '0;
        end else begin
            mode_q <= mode;
            if (arr_start) begin
                pend_tag <= req_row;
            end
            if (mode != mode_q) begin
                buf_valid <= 1'b0;
            end else if (buf_load) begin
                buf_valid <= 1'b1;
                buf_tag   <= pend_tag;
                buf_row   <= arr_data;
            end
        end
    end

    // Assertions
    p_err_completes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_ready && (rsp_data == '0)));

    p_unclaimed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_en || !in_window) |-> (!rsp_ready && !rsp_err));

    p_ready_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> req_valid);

    p_stall_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !rsp_ready);

    p_fetch_then_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_LOAD));

    p_load_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOAD) && (mode == mode_q)) |=> buf_valid);

    p_mode_inval_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != mode_q) |=> !buf_valid);

    p_bad_no_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err) |=> (state_q == ST_IDLE));

endmodule

// File: tb/test_rom_bridge.sv
`timescale 1ns/1ps
module test_rom_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic        rsp_ready;
    logic [31:0] rsp_data;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the buffer
    bit          m_valid = 1'b0;
    logic [14:0] m_tag = '0;

    always #4 clk = ~clk;

    rom_bridge i_rom_bridge (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    function automatic logic [63:0] exp_row(input logic [14:0] r);
        logic [31:0] w;
        w = {17'd0, r};
        return {(w * 32'h0100_0193) ^ 32'hC3A5_0F1E, (w * 32'h9E37_79B9) + 32'h0000_5A5A};
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] a, input logic [1:0] sz);
        logic [63:0] row;
        logic [31:0] w;
        int sh;
        row = exp_row(a[17:3]);
        w = a[2] ? row[31:0] : row[63:32];
        case (sz)
            2'd0: begin sh = 24 - 8 * int'(a[1:0]); return ((w >> sh) & 32'hFF) << sh; end
            2'd1: begin sh = a[1] ? 0 : 16; return ((w >> sh) & 32'hFFFF) << sh; end
            2'd2: return w;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        if (m != mode) m_valid = 1'b0;
        mode = m;
        @(negedge clk);
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr, input string req);
        bit claimed, bad, hit, got;
        int n, lat_exp;
        logic [31:0] d;
        logic e;
        claimed = (a[31:18] == 0) && (mode <= 3'd1);
        bad = wr || (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 0);
        hit = m_valid && (m_tag == a[17:3]);
        lat_exp = (bad || hit) ? 1 : 4;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        n = 0; got = 0; d = '0; e = 1'b0;
        while (!got && n < (claimed ? 20 : 6)) begin
            #3;
            n++;
            if (rsp_ready || rsp_err) begin got = 1; d = rsp_data; e = rsp_err; end
            @(negedge clk);
        end
        req_valid = 1'b0; req_write = 1'b0;
        if (!claimed) begin
            check(!got, req, 32'(got), 32'd0);
        end else begin
            check(got && n == lat_exp, req, 32'(n), 32'(lat_exp));
            check(e == bad, req, 32'(e), 32'(bad));
            check(d == (bad ? 32'h0 : exp_data(a, sz)), req, d, bad ? 32'h0 : exp_data(a, sz));
            if (!bad && !hit) begin m_valid = 1'b1; m_tag = a[17:3]; end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #2;
        check(!rsp_ready && !rsp_err, "R1 reset outputs", {30'd0, rsp_ready, rsp_err}, 32'd0);
        rst_n = 1'b1;
        // R1 / R4: first read misses
        access(32'h0000_0000, 2'd2, 1'b0, "R1 R4 first miss");
        access(32'h0000_0004, 2'd2, 1'b0, "R5 R6 hit lower word");
        access(32'h0000_0000, 2'd2, 1'b0, "R6 upper word");
        for (int k = 0; k < 8; k++) access(32'(k), 2'd0, 1'b0, "R8 byte lanes");
        for (int k = 0; k < 8; k += 2) access(32'(k), 2'd1, 1'b0, "R7 half lanes");
        access(32'h0000_0003, 2'd1, 1'b0, "R9 odd halfword");
        access(32'h0000_0006, 2'd2, 1'b0, "R9 misaligned word");
        access(32'h0000_0004, 2'd3, 1'b0, "R9 reserved size");
        access(32'h0003_FFF8, 2'd1, 1'b1, "R10 write ignored");
        access(32'h0000_0004, 2'd2, 1'b0, "R9 R10 buffer kept");
        access(32'h0003_FFFC, 2'd2, 1'b0, "R2 last row miss");
        access(32'h0004_0000, 2'd2, 1'b0, "R2 outside window");
        access(32'h8000_0000, 2'd0, 1'b1, "R2 outside write");
        for (int m = 2; m <= 4; m++) begin
            set_mode(3'(m));
            access(32'h0003_FFFC, 2'd2, 1'b0, "R3 mode disables");
        end
        set_mode(3'd1);
        access(32'h0003_FFFC, 2'd2, 1'b0, "R3 R11 mode 1 after change");
        access(32'h0003_FFF8, 2'd0, 1'b0, "R5 hit in mode 1");
        set_mode(3'd0);
        access(32'h0003_FFF9, 2'd0, 1'b0, "R11 mode change invalidates");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [1:0] sz;
            bit wr;
            if ($urandom_range(0, 24) == 0) set_mode(3'($urandom_range(0, 4)));
            a = {14'd0, 15'($urandom_range(0, 5)), 3'($urandom_range(0, 7))};
            if ($urandom_range(0, 3) == 0) a[17:3] = 15'($urandom);
            if ($urandom_range(0, 15) == 0) a[31:18] = 14'($urandom);
            sz = 2'($urandom_range(0, 3));
            if (sz != 2'd0 && $urandom_range(0, 3) != 0) begin
                a[0] = 1'b0;
                if (sz == 2'd2) a[1] = 1'b0;
            end
            wr = ($urandom_range(0, 15) == 0);
            access(a, sz, wr, "R4 R5 R6 R7 R8 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule